// File: doc/BRIEF.md
# Signed Piecewise-Linear Table Interpolator

This block approximates a function by straight segments between signed sample points. A 16-bit fixed-point argument carries an unsigned 8-bit integer part in bits 15..8 and an 8-bit fraction in bits 7..0. The integer part picks a segment and the fraction gives the position inside it. The block takes the two end points of the segment, ENTRY(n) and ENTRY(n+1), and returns the value between them.

The end points come from one of two places. In lookup mode the block fetches them from a table in memory through a simple read port: ENTRY(n) first, then the entry that follows it. In register mode a caller supplies them directly on two operand inputs and no memory traffic takes place.

Each entry is a signed byte, word or long word. The result is returned either rounded to the size of the entries or unrounded with 8 extra fraction bits. An overflow flag covers the single case whose result can exceed 32 bits.

Top module: `tbl_interp`

## Requirements
- R1: While and after reset, and before the first operation, `done_o`, `mem_req_o`, `ovf_o` and `result_o` are all zero.
- R2: `size_i` selects the entry size: 0 is byte (1 byte), 1 is word (2 bytes), 2 and 3 are long word (4 bytes). In lookup mode the first read address is `base_i + x_i[15:8] * bytes`. The second read address is the first plus `bytes`.
- R3: `mem_req_o` stays high with a stable `mem_addr_o` until a cycle in which `mem_valid_i` is high. The entry is taken from the low `bytes*8` bits of `mem_rdata_i` in that cycle. Lookup mode makes exactly two such reads per operation.
- R4: Entries are treated as signed and are sign-extended from the selected size. Bits above that size, in memory data or in register operands, have no effect.
- R5: With `round_i`=1 the result is E0 + ((E1-E0)*F + 128) >>> 8. Here F = `x_i[7:0]`, and halves round toward positive infinity.
- R6: With `round_i`=0 the result is E0*256 + (E1-E0)*F, a value with 8 fraction bits.
- R7: With `mode_reg_i`=1, `ent_a_i` is ENTRY(n) and `ent_b_i` is ENTRY(n+1). No memory request is made, and `x_i[15:8]` has no effect on the result.
- R8: `done_o` is a one-cycle pulse. In register mode it is high in the second cycle after the start edge. In lookup mode it is high two cycles after the edge that accepts the second read. `result_o` and `ovf_o` hold their values until the next `done_o`.
- R9: `result_o` is the low 32 bits of the result, sign-extended to 32 bits. `ovf_o` is 1 only when an unrounded long-word result does not fit in signed 32 bits.
- R10: A fraction of zero returns exactly E0 (rounded) or E0*256 (unrounded).
- R11: A `start_i` pulse that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| mode_reg_i | input | 1 | 1: end points from the register operands; 0: end points from the memory table |
| size_i | input | 2 | Entry size code (0 byte, 1 word, 2/3 long word) |
| round_i | input | 1 | 1: rounded result; 0: unrounded result with 8 fraction bits |
| x_i | input | 16 | Argument: integer part in bits 15..8, fraction in bits 7..0 |
| base_i | input | AW | Byte address of the start of the table |
| ent_a_i | input | 32 | Register operand used as ENTRY(n) |
| ent_b_i | input | 32 | Register operand used as ENTRY(n+1) |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | AW | Read byte address |
| mem_valid_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | 32 | Read data, entry right-justified |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Interpolated result |
| ovf_o | output | 1 | Unrounded long-word result overflowed 32 bits |

## Verification
In register mode the result is due in the second cycle after the start edge. In lookup mode it is due 4 + 2L cycles after the start edge, where L is the number of wait cycles the bench memory inserts before each read. The bench drives inputs on the falling edge and counts falling edges until `done_o` appears. It checks that count against these figures, so a late or early result is reported even when the value is right. Results, overflow flags and read addresses are all compared in the same sample as `done_o`. After that sample the bench holds a few idle cycles, to confirm that a start pulse sent during the operation caused no second completion.

// File: rtl/tbl_interp_pkg.sv
package tbl_interp_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 8;
    localparam int FRAC_W = 8;
    localparam int ACC_W  = DATA_W + 2 + FRAC_W;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_LONG3 = 2'd3
    } ent_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD0  = 2'd1,
        ST_RD1  = 2'd2,
        ST_CALC = 2'd3
    } ctl_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] e0;
        logic [DATA_W-1:0] e1;
        logic [FRAC_W-1:0] frac;
        logic              rnd;
    } alu_op_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              ovf;
    } alu_res_t;

    function automatic logic [1:0] size_shift(ent_size_e s);
        case (s)
            SZ_BYTE: return 2'd0;
            SZ_WORD: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] sext_entry(logic [DATA_W-1:0] raw, ent_size_e s);
        case (s)
            SZ_BYTE: return {{(DATA_W-8){raw[7]}}, raw[7:0]};
            SZ_WORD: return {{(DATA_W-16){raw[15]}}, raw[15:0]};
            default: return raw;
        endcase
    endfunction

endpackage

// File: rtl/tbl_interp_addr.sv
module tbl_interp_addr
    import tbl_interp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    base_i,
    input  logic [IDX_W-1:0] idx_i,
    input  ent_size_e        size_i,
    input  logic             second_i,
    output logic [AW-1:0]    addr_o
);
    logic [1:0]    sh;
    logic [AW-1:0] offs;
    logic [AW-1:0] step;

    always_comb begin
        sh     = size_shift(size_i);
        offs   = AW'(idx_i) << sh;
        step   = second_i ? (AW'(1) << sh) : '0;
        addr_o = base_i + offs + step;
    end
endmodule

// File: rtl/tbl_interp_ctl.sv
module tbl_interp_ctl
    import tbl_interp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       mode_reg_i,
    input  logic       mem_valid_i,
    output ctl_state_e state_o,
    output logic       accept_o,
    output logic       cap0_o,
    output logic       cap1_o,
    output logic       calc_o,
    output logic       req_o,
    output logic       second_o
);
    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start_i) state_d = mode_reg_i ? ST_CALC : ST_RD0;
            ST_RD0:  if (mem_valid_i) state_d = ST_RD1;
            ST_RD1:  if (mem_valid_i) state_d = ST_CALC;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_o  = state_q;
        accept_o = (state_q == ST_IDLE) && start_i;
        cap0_o   = (state_q == ST_RD0) && mem_valid_i;
        cap1_o   = (state_q == ST_RD1) && mem_valid_i;
        calc_o   = (state_q == ST_CALC);
        req_o    = (state_q == ST_RD0) || (state_q == ST_RD1);
        second_o = (state_q == ST_RD1);
    end
endmodule

// File: rtl/tbl_interp_alu.sv
module tbl_interp_alu
    import tbl_interp_pkg::*;
(
    input  alu_op_t  op_i,
    output alu_res_t res_o
);
    logic signed [ACC_W-1:0] e0_w, e1_w, diff_w, frac_w, prod_w, rnd_w, unr_w, sel_w;

    always_comb begin
        e0_w   = ACC_W'($signed(op_i.e0));
        e1_w   = ACC_W'($signed(op_i.e1));
        diff_w = e1_w - e0_w;
        frac_w = $signed({{(ACC_W-FRAC_W){1'b0}}, op_i.frac});
        prod_w = diff_w * frac_w;
        rnd_w  = e0_w + ((prod_w + ACC_W'(128)) >>> FRAC_W);
        unr_w  = (e0_w <<< FRAC_W) + prod_w;
        sel_w  = op_i.rnd ? rnd_w : unr_w;
        res_o.value = sel_w[DATA_W-1:0];
        res_o.ovf   = !op_i.rnd &&
                      (unr_w[ACC_W-1:DATA_W-1] != {(ACC_W-DATA_W+1){unr_w[DATA_W-1]}});
    end
endmodule

// File: rtl/tbl_interp.sv
module tbl_interp
    import tbl_interp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              mode_reg_i,
    input  logic [1:0]        size_i,
    input  logic              round_i,
    input  logic [15:0]       x_i,
    input  logic [AW-1:0]     base_i,
    input  logic [31:0]       ent_a_i,
    input  logic [31:0]       ent_b_i,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              done_o,
    output logic [31:0]       result_o,
    output logic              ovf_o
);
    ctl_state_e        state;
    logic              accept, cap0, cap1, calc, second;
    alu_op_t           op_q;
    alu_res_t          res_w;
    ent_size_e         size_q;
    logic [IDX_W-1:0]  idx_q;
    logic [AW-1:0]     base_q;
    logic              done_q, ovf_q;
    logic [DATA_W-1:0] result_q;
    ent_size_e         size_in;

    assign size_in = ent_size_e'(size_i);

    tbl_interp_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .mode_reg_i  (mode_reg_i),
        .mem_valid_i (mem_valid_i),
        .state_o     (state),
        .accept_o    (accept),
        .cap0_o      (cap0),
        .cap1_o      (cap1),
        .calc_o      (calc),
        .req_o       (mem_req_o),
        .second_o    (second)
    );

    tbl_interp_addr #(.AW(AW)) u_addr (
        .base_i   (base_q),
        .idx_i    (idx_q),
        .size_i   (size_q),
        .second_i (second),
        .addr_o   (mem_addr_o)
    );

    tbl_interp_alu u_alu (
        .op_i  (op_q),
        .res_o (res_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= '0;
            size_q   <= SZ_BYTE;
            idx_q    <= '0;
            base_q   <= '0;
            done_q   <= 1'b0;
            ovf_q    <= 1'b0;
            result_q <= '0;
        end else begin
            if (accept) begin
                op_q.frac <= x_i[FRAC_W-1:0];
                op_q.rnd  <= round_i;
                idx_q     <= x_i[15:FRAC_W];
                size_q    <= size_in;
                base_q    <= base_i;
                if (mode_reg_i) begin
                    op_q.e0 <= sext_entry(ent_a_i, size_in);
                    op_q.e1 <= sext_entry(ent_b_i, size_in);
                end
            end
            if (cap0) op_q.e0 <= sext_entry(mem_rdata_i, size_q);
            if (cap1) op_q.e1 <= sext_entry(mem_rdata_i, size_q);
            done_q <= calc;
            if (calc) begin
                result_q <= res_w.value;
                ovf_q    <= res_w.ovf;
            end
        end
    end

    assign done_o   = done_q;
    assign result_o = result_q;
    assign ovf_o    = ovf_q;
endmodule

// File: rtl/tbl_interp_chk.sv
module tbl_interp_chk
    import tbl_interp_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          done_o,
    input logic          mem_req_o,
    input logic          mem_valid_i,
    input logic [AW-1:0] mem_addr_o,
    input logic [31:0]   result_o,
    input logic          ovf_o,
    input ent_size_e     size_q,
    input logic          second,
    input alu_op_t       op_q
);
    logic [AW-1:0] step;
    assign step = AW'(1) << size_shift(size_q);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R3
    AST_NEXT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_valid_i && !second) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + $past(step))); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (done_o && (size_q == SZ_BYTE || size_q == SZ_WORD || op_q.rnd)) |-> !ovf_o); // R9
    AST_REQ_NOT_DONE: assert property (@(posedge clk) disable iff (rst) mem_req_o |-> !done_o); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |=> (done_o || ($stable(result_o) && $stable(ovf_o)))); // R8
endmodule

bind tbl_interp tbl_interp_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .done_o      (done_o),
    .mem_req_o   (mem_req_o),
    .mem_valid_i (mem_valid_i),
    .mem_addr_o  (mem_addr_o),
    .result_o    (result_o),
    .ovf_o       (ovf_o),
    .size_q      (size_q),
    .second      (second),
    .op_q        (op_q)
);

// File: tb/tbl_interp_tb_top.sv
module tbl_interp_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, mode_reg_i = 1'b0, round_i = 1'b0;
    logic [1:0]  size_i = 2'd0;
    logic [15:0] x_i = '0;
    logic [31:0] base_i = '0, ent_a_i = '0, ent_b_i = '0;
    logic        mem_req_o, mem_valid_i = 1'b0, done_o, ovf_o;
    logic [31:0] mem_addr_o, mem_rdata_i = '0, result_o;

    int errors = 0, checks = 0, lat = 0, wcnt = 0, acc_n = 0, done_n = 0;
    logic [31:0] acc_addr [2];
    bit finished = 0;

    always #5 clk = ~clk;

    tbl_interp #(.AW(32)) dut_i (.*);

    function automatic logic [31:0] tbl_word(logic [31:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] + 8'h3C, a[7:0] * 8'd37, a[7:0] * 8'd91 + 8'd7};
    endfunction

    function automatic longint sx(logic [31:0] r, logic [1:0] sz);
        case (sz)
            2'd0:    return longint'($signed(r[7:0]));
            2'd1:    return longint'($signed(r[15:0]));
            default: return longint'($signed(r));
        endcase
    endfunction

    // memory responder: L wait cycles before each valid
    always @(negedge clk) begin
        if (done_o) done_n++;
        if (mem_req_o) begin
            if (wcnt == 0) begin
                mem_valid_i = 1'b1;
                mem_rdata_i = tbl_word(mem_addr_o);
                acc_addr[acc_n % 2] = mem_addr_o;
                acc_n++;
                wcnt = lat;
            end else begin
                mem_valid_i = 1'b0;
                wcnt--;
            end
        end else begin
            mem_valid_i = 1'b0;
            wcnt = lat;
        end
    end

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(bit mode, logic [1:0] sz, bit rnd, logic [15:0] x,
                          logic [31:0] base, logic [31:0] a, logic [31:0] b,
                          int l, bit poke);
        int bytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        logic [31:0] a0 = base + 32'(x[15:8]) * 32'(bytes);
        longint e0, e1, p, full, expv;
        bit expo;
        int cnt = 0, n0, d0, explat;
        e0 = mode ? sx(a, sz) : sx(tbl_word(a0), sz);
        e1 = mode ? sx(b, sz) : sx(tbl_word(a0 + 32'(bytes)), sz);
        p = (e1 - e0) * longint'(x[7:0]);
        full = rnd ? e0 + ((p + 128) >>> 8) : e0 * 256 + p;
        expo = !rnd && (full > 64'sh7FFFFFFF || full < -64'sh80000000);
        expv = longint'($signed(full[31:0]));
        lat = l;
        @(negedge clk);
        n0 = acc_n; d0 = done_n;
        start_i = 1; mode_reg_i = mode; size_i = sz; round_i = rnd;
        x_i = x; base_i = base; ent_a_i = a; ent_b_i = b;
        while (cnt < 100) begin
            @(negedge clk);
            cnt++;
            start_i = poke && (cnt == 1);
            if (poke) begin mode_reg_i = 1; ent_a_i = 32'h11; ent_b_i = 32'h22; x_i = 16'h0080; end
            if (done_o) break;
        end
        explat = mode ? 2 : 4 + 2 * l;
        check(cnt == explat, "R8 latency", cnt, explat);
        check(longint'($signed(result_o)) == expv, rnd ? "R5 rounded" : "R6 unrounded",
              longint'($signed(result_o)), expv);
        check(ovf_o == expo, "R9 overflow", ovf_o, expo);
        if (x[7:0] == 0)
            check(longint'($signed(result_o)) == (rnd ? e0 : longint'($signed(32'(e0 * 256)))),
                  "R10 zero fraction", longint'($signed(result_o)), e0);
        if (mode)
            check(acc_n == n0, "R7 no memory read", acc_n - n0, 0);
        else begin
            check(acc_n - n0 == 2, "R3 read count", acc_n - n0, 2);
            check(acc_addr[n0 % 2] == a0, "R2 first address", acc_addr[n0 % 2], a0);
            check(acc_addr[(n0 + 1) % 2] == a0 + 32'(bytes), "R2 second address",
                  acc_addr[(n0 + 1) % 2], a0 + 32'(bytes));
        end
        if (poke) begin
            repeat (6) @(negedge clk);
            check(done_n - d0 == 1, "R11 start while busy", done_n - d0, 1);
            check(longint'($signed(result_o)) == expv, "R11 result kept",
                  longint'($signed(result_o)), expv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa[6] = '{32'h0, 32'h7F, 32'hFFFF_FF80, 32'h1234_5678, 32'h8000_0000, 32'h7FFF_FFFF};
        logic [31:0] pb[6] = '{32'h1, 32'hFFFF_FF81, 32'h7F, 32'hFFFF_8001, 32'h7FFF_FFFF, 32'h8000_0000};
        logic [7:0]  fr[8] = '{8'd0, 8'd1, 8'd2, 8'd127, 8'd128, 8'd129, 8'd254, 8'd255};
        logic [7:0]  ip[5] = '{8'd0, 8'd1, 8'd127, 8'd128, 8'd255};
        logic [7:0]  lf[4] = '{8'd0, 8'd77, 8'd128, 8'd255};
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!done_o && !mem_req_o && !ovf_o && result_o == 0, "R1 reset outputs", result_o, 0);
        rst = 0;
        @(negedge clk);
        check(!done_o && !mem_req_o && result_o == 0, "R1 idle outputs", result_o, 0);
        // R4 upper bits ignored, R5 halves round up
        run_op(1, 2'd0, 1, 16'h3300, 0, 32'hABCD_1280, 32'h0000_0080, 0, 0);
        run_op(1, 2'd0, 1, 16'h0080, 0, 32'h0, 32'hFFFF_FF01, 0, 0);
        run_op(1, 2'd1, 1, 16'h0080, 0, 32'h0, 32'h1, 0, 0);
        // R9 long unrounded overflow
        run_op(1, 2'd2, 0, 16'h0000, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0);
        run_op(1, 2'd2, 0, 16'h00FF, 0, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0);
        // R7 register-mode sweep, integer part varied
        for (int s = 0; s < 4; s++)
            for (int r = 0; r < 2; r++)
                for (int f = 0; f < 8; f++)
                    for (int k = 0; k < 6; k++)
                        run_op(1, 2'(s), r[0], {8'(k * 53 + f), fr[f]}, 0, pa[k], pb[k], 0, 0);
        // R2 R3 lookup sweep with varied wait cycles
        for (int s = 0; s < 4; s++)
            for (int r = 0; r < 2; r++)
                for (int i = 0; i < 5; i++)
                    for (int f = 0; f < 4; f++)
                        run_op(0, 2'(s), r[0], {ip[i], lf[f]}, 32'h0000_1000 + 32'(i * 7),
                               0, 0, (i + f) % 3, 0);
        // R11 start pulse during a lookup
        run_op(0, 2'd1, 1, 16'h0540, 32'h200, 0, 0, 3, 1);
        run_op(0, 2'd2, 0, 16'hFE11, 32'hFFFF_FF00, 0, 0, 2, 1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule